// File: doc/BRIEF.md
# Channel Hit Data Packer

When a readout trigger arrives, this block walks through the per-channel hit records of 48 drift channels. It turns them into a stream of 32-bit words for readout. Each record is 16 bits wide: an 8-bit leading-edge time and an 8-bit pulse width. Every output word carries two records. The records go out in a fixed order, and a record may share a word with a record from a different channel.

The hit storage sits outside the block and is read without latency. The block puts out a channel number and a hit index, and the storage answers in the same cycle with that channel's stored hit count and the addressed record. Two software settings shape the scan. A per-channel enable mask leaves out channels. A 3-bit hits-to-process limit cuts each channel down to its first few hits. The words leave through a valid/ready handshake. After the last word a one-cycle done pulse carries the number of records sent, which a later stage places into the event header.

Top module: `hit_packer`

## Requirements
- R1: A record is `{lead[7:0], width[7:0]}` as returned on `memRecord`. In each output word the earlier record sits in bits 31..16 and the later record in bits 15..0.
- R2: Records go out in ascending channel order, 0 to 47, and by ascending hit index within a channel. The record after a channel's last emitted hit is the first record of the next channel that contributes. It fills the lower half of the current word when that half is free.
- R3: A channel whose `chanMask` bit is 0 contributes no records, whatever its stored count.
- R4: A channel contributes the smaller of its stored count and `hitLimit`, always its lowest-indexed hits. A limit of 0 produces no records.
- R5: When the number of emitted records is odd, bits 15..0 of the final word are zero.
- R6: While `outValid` is high and `outReady` is low, `outValid` stays high and `outWord` holds its value.
- R7: `done` is high for exactly one cycle per trigger. It is never high together with `outValid`, and it comes after the last word is accepted. When it is high, `doneTotal` gives the number of records emitted. An event with no records gives a done pulse with total 0 and no words.
- R8: At most 96 words are emitted per event. Records beyond the 192nd are dropped and not counted in `doneTotal`.
- R9: A trigger that arrives while a scan or its done cycle is in progress is ignored. The output sequence and the single done pulse are unchanged.
- R10: After reset, `outValid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Readout trigger; starts a scan when idle |
| chanMask | input | 48 | Per-channel enable; 0 removes the channel |
| hitLimit | input | 3 | Maximum records taken from each channel |
| memChan | output | 6 | Channel addressed in hit storage |
| memHit | output | 3 | Hit index addressed in hit storage |
| memCount | input | 3 | Stored hit count of `memChan` (same cycle) |
| memRecord | input | 16 | Record at (`memChan`, `memHit`) (same cycle) |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Consumer accepts the word |
| outWord | output | 32 | Two packed records |
| done | output | 1 | One-cycle end-of-event pulse |
| doneTotal | output | 8 | Records emitted in the event, valid with `done` |

## Verification
The bench aims at the points where records cross channel boundaries inside a word. A packer that flushed a word at every channel change would send half-empty words and break the sequence. Masked channels with large stored counts, and limits of 0 and 2, show whether the mask and the truncation are applied before packing; a wrong design would leak records or take hits from the wrong end of a channel. Full channels at limit 7 hit the 96-word cap. A design without the cap overruns it, and one that counts dropped records gets the wrong total. An odd record count shows whether stale data is left in the lower half. Irregular backpressure and a mid-scan trigger reveal words that change while stalled or a scan that restarts.

// File: rtl/hitpack_pkg.sv
package hitpack_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;     // start of event: reset indices, totals and word halves
    logic latchEff;  // capture effective hit count of the current channel
    logic loadRec;   // place the addressed record into the free half
    logic advChan;   // step to the next channel
    logic wordSent;  // a word left through the handshake
  } ctlStrobe_t;

  // Conditions reported back by the datapath
  typedef struct packed {
    logic effZero;   // current channel contributes nothing
    logic lastChan;  // current channel is the highest one
    logic half;      // upper half holds a record, lower half free
    logic hitsLeft;  // records remain in the current channel
    logic recLast;   // the record being loaded is the channel's last
    logic wordCap;   // the word being sent is the last allowed
  } dpStatus_t;

endpackage

// File: rtl/hitpack_datapath.sv
module hitpack_datapath
  import hitpack_pkg::*;
#(
  parameter int NUM_CHAN  = 48,
  parameter int CNT_W     = 3,
  parameter int EDGE_W    = 8,
  parameter int MAX_WORDS = 96,
  localparam int REC_W    = 2 * EDGE_W,
  localparam int WORD_W   = 2 * REC_W,
  localparam int CHAN_W   = $clog2(NUM_CHAN),
  localparam int WCNT_W   = $clog2(MAX_WORDS + 1),
  localparam int TOT_W    = $clog2(2 * MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [NUM_CHAN-1:0] chanMask,
  input  logic [CNT_W-1:0]  hitLimit,
  input  logic [CNT_W-1:0]  memCount,
  input  logic [REC_W-1:0]  memRecord,
  output logic [CHAN_W-1:0] memChan,
  output logic [CNT_W-1:0]  memHit,
  output logic [WORD_W-1:0] packedWord,
  output logic [TOT_W-1:0]  recTotal,
  output dpStatus_t         sts
);

  logic [CHAN_W-1:0] chanIdx;
  logic [CNT_W-1:0]  hitIdx;
  logic [CNT_W-1:0]  effReg;
  logic [CNT_W-1:0]  effNow;
  logic [REC_W-1:0]  upperRec;
  logic [REC_W-1:0]  lowerRec;
  logic              halfFull;
  logic [WCNT_W-1:0] wordCnt;
  logic [CNT_W:0]    hitNext;

  // Effective contribution of the channel under the address
  always_comb begin
    if (!chanMask[chanIdx])
      effNow = '0;
    else if (memCount < hitLimit)
      effNow = memCount;
    else
      effNow = hitLimit;
  end

  assign hitNext = {1'b0, hitIdx} + 1'b1;

  always_comb begin
    sts.effZero  = (effNow == '0);
    sts.lastChan = (chanIdx == CHAN_W'(NUM_CHAN - 1));
    sts.half     = halfFull;
    sts.hitsLeft = (hitIdx < effReg);
    sts.recLast  = (hitNext == {1'b0, effReg});
    sts.wordCap  = (wordCnt == WCNT_W'(MAX_WORDS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      chanIdx  <= '0;
      hitIdx   <= '0;
      effReg   <= '0;
      upperRec <= '0;
      lowerRec <= '0;
      halfFull <= 1'b0;
      wordCnt  <= '0;
      recTotal <= '0;
    end else begin
      if (stb.latchEff) begin
        effReg <= effNow;
        hitIdx <= '0;
      end
      if (stb.loadRec) begin
        if (!halfFull) begin
          upperRec <= memRecord;
          lowerRec <= '0;
          halfFull <= 1'b1;
        end else begin
          lowerRec <= memRecord;
          halfFull <= 1'b0;
        end
        hitIdx   <= hitIdx + 1'b1;
        recTotal <= recTotal + 1'b1;
      end
      if (stb.advChan)
        chanIdx <= chanIdx + 1'b1;
      if (stb.wordSent) begin
        wordCnt  <= wordCnt + 1'b1;
        halfFull <= 1'b0;
      end
    end
  end

  assign memChan    = chanIdx;
  assign memHit     = hitIdx;
  assign packedWord = {upperRec, lowerRec};

  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    chanIdx < CHAN_W'(NUM_CHAN)); // R2
  AST_LOAD_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadRec |-> (hitIdx < effReg) && (hitIdx < hitLimit)); // R4
  AST_WORD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    stb.wordSent |-> wordCnt < WCNT_W'(MAX_WORDS)); // R8
  AST_TOTAL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    recTotal <= TOT_W'(2 * MAX_WORDS)); // R8

endmodule

// File: rtl/hitpack_ctrl.sv
module hitpack_ctrl
  import hitpack_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       trig,
  input  logic       outReady,
  input  dpStatus_t  sts,
  output ctlStrobe_t stb,
  output logic       outValid,
  output logic       done
);

  typedef enum logic [2:0] {
    sIdle, sChan, sHit, sOut, sFlush, sDone
  } scanState_t;

  scanState_t state, stateNext;

  always_comb begin
    stateNext = state;
    stb       = '0;
    outValid  = 1'b0;
    done      = 1'b0;
    unique case (state)
      sIdle: begin
        if (trig) begin
          stb.clear = 1'b1;
          stateNext = sChan;
        end
      end
      sChan: begin
        if (sts.effZero) begin
          if (sts.lastChan)
            stateNext = sts.half ? sFlush : sDone;
          else
            stb.advChan = 1'b1;
        end else begin
          stb.latchEff = 1'b1;
          stateNext    = sHit;
        end
      end
      sHit: begin
        stb.loadRec = 1'b1;
        if (sts.half) begin
          stateNext = sOut;
        end else if (sts.recLast) begin
          if (sts.lastChan) begin
            stateNext = sFlush;
          end else begin
            stb.advChan = 1'b1;
            stateNext   = sChan;
          end
        end
      end
      sOut: begin
        outValid = 1'b1;
        if (outReady) begin
          stb.wordSent = 1'b1;
          if (sts.wordCap) begin
            stateNext = sDone;
          end else if (sts.hitsLeft) begin
            stateNext = sHit;
          end else if (sts.lastChan) begin
            stateNext = sDone;
          end else begin
            stb.advChan = 1'b1;
            stateNext   = sChan;
          end
        end
      end
      sFlush: begin
        outValid = 1'b1;
        if (outReady) begin
          stb.wordSent = 1'b1;
          stateNext    = sDone;
        end
      end
      sDone: begin
        done      = 1'b1;
        stateNext = sIdle;
      end
      default: stateNext = sIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= sIdle;
    else       state <= stateNext;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_DONE_NOT_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !(done && outValid)); // R7
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (state != sIdle) && trig |=> !stb.clear || $past(state) == sDone); // R9

endmodule

// File: rtl/hit_packer.sv
module hit_packer
  import hitpack_pkg::*;
#(
  parameter int NUM_CHAN  = 48,
  parameter int CNT_W     = 3,
  parameter int EDGE_W    = 8,
  parameter int MAX_WORDS = 96,
  localparam int REC_W    = 2 * EDGE_W,
  localparam int WORD_W   = 2 * REC_W,
  localparam int CHAN_W   = $clog2(NUM_CHAN),
  localparam int TOT_W    = $clog2(2 * MAX_WORDS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                trig,
  input  logic [NUM_CHAN-1:0] chanMask,
  input  logic [CNT_W-1:0]    hitLimit,
  output logic [CHAN_W-1:0]   memChan,
  output logic [CNT_W-1:0]    memHit,
  input  logic [CNT_W-1:0]    memCount,
  input  logic [REC_W-1:0]    memRecord,
  output logic                outValid,
  input  logic                outReady,
  output logic [WORD_W-1:0]   outWord,
  output logic                done,
  output logic [TOT_W-1:0]    doneTotal
);

  ctlStrobe_t stb;
  dpStatus_t  sts;

  hitpack_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .trig     (trig),
    .outReady (outReady),
    .sts      (sts),
    .stb      (stb),
    .outValid (outValid),
    .done     (done)
  );

  hitpack_datapath #(
    .NUM_CHAN  (NUM_CHAN),
    .CNT_W     (CNT_W),
    .EDGE_W    (EDGE_W),
    .MAX_WORDS (MAX_WORDS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .chanMask   (chanMask),
    .hitLimit   (hitLimit),
    .memCount   (memCount),
    .memRecord  (memRecord),
    .memChan    (memChan),
    .memHit     (memHit),
    .packedWord (outWord),
    .recTotal   (doneTotal),
    .sts        (sts)
  );

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outWord)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> !outValid && !done); // R10

endmodule

// File: tb/sim_hit_packer.sv
module sim_hit_packer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trig = 1'b0;
  logic [47:0] chanMask = '1;
  logic [2:0]  hitLimit = 3'd7;
  logic [5:0]  memChan;
  logic [2:0]  memHit;
  logic [2:0]  memCount;
  logic [15:0] memRecord;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [31:0] outWord;
  logic        done;
  logic [7:0]  doneTotal;

  int nRun = 0;
  int nFail = 0;
  int cycles = 0;

  logic [2:0]  cntMem [48];
  logic [15:0] recMem [384];
  logic [31:0] expWords [256];
  logic [31:0] gotWords [256];
  int expN, expTot, gotN, gotTot;
  bit gotDone, extraAct;

  always #2 clk = ~clk;

  hit_packer u0 (
    .clk(clk), .rstN(rstN), .trig(trig), .chanMask(chanMask), .hitLimit(hitLimit),
    .memChan(memChan), .memHit(memHit), .memCount(memCount), .memRecord(memRecord),
    .outValid(outValid), .outReady(outReady), .outWord(outWord),
    .done(done), .doneTotal(doneTotal)
  );

  assign memCount  = (memChan < 6'd48) ? cntMem[memChan] : 3'd0;
  assign memRecord = (memChan < 6'd48) ? recMem[{memChan, memHit}] : 16'h0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nFail = nFail + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", nRun + 1, nFail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fillMem(input int seed, input int fixedCnt);
    for (int c = 0; c < 48; c++) begin
      cntMem[c] = (fixedCnt >= 0) ? 3'(fixedCnt) : 3'((c * 3 + seed) % 6);
      for (int h = 0; h < 8; h++)
        recMem[c * 8 + h] = {8'(c * 7 + h + seed), 8'(h * 31 + c + seed * 3)};
    end
  endtask

  // Reference packing computed from the requirements
  task automatic buildExpected();
    int n = 0;
    logic [15:0] recs [192];
    for (int c = 0; c < 48; c++) begin
      int eff = 0;
      if (chanMask[c]) eff = (int'(cntMem[c]) < int'(hitLimit)) ? int'(cntMem[c]) : int'(hitLimit);
      for (int h = 0; h < eff; h++)
        if (n < 192) begin recs[n] = recMem[c * 8 + h]; n++; end
    end
    expTot = n;
    expN = (n + 1) / 2;
    for (int w = 0; w < expN; w++)
      expWords[w] = {recs[2 * w], (2 * w + 1 < n) ? recs[2 * w + 1] : 16'h0};
  endtask

  task automatic runEvent(input bit backpress, input bit midTrig);
    int k = 0;
    gotN = 0; gotTot = -1; gotDone = 0; extraAct = 0;
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    while (!gotDone && k < 4000) begin
      outReady = backpress ? ((k % 3) != 1) : 1'b1;
      trig = midTrig && (k == 6 || k == 40);
      #1;
      if (outValid && outReady) begin
        if (gotN < 256) gotWords[gotN] = outWord;
        gotN++;
      end
      if (done) begin gotDone = 1; gotTot = int'(doneTotal); end
      @(negedge clk);
      k++;
    end
    trig = 1'b0;
    for (int i = 0; i < 20; i++) begin
      #1;
      if (outValid || done) extraAct = 1;
      @(negedge clk);
    end
  endtask

  task automatic compareWords(input string req);
    int bad = -1;
    for (int w = 0; w < expN && w < gotN; w++)
      if (bad < 0 && gotWords[w] !== expWords[w]) bad = w;
    nRun++;
    if (bad >= 0) begin
      nFail++;
      $display("FAIL %s: word %0d actual %h expected %h", req, bad, gotWords[bad], expWords[bad]);
    end
  endtask

  task automatic checkEvent(input string req, input bit backpress, input bit midTrig);
    buildExpected();
    runEvent(backpress, midTrig);
    check({req, " done seen"}, int'(gotDone), 1);
    check({req, " word count"}, gotN, expN);
    compareWords(req);
    check({req, " total"}, gotTot, expTot);
    check({req, " quiet after done (R7)"}, int'(extraAct), 0);
  endtask

  task automatic testReset();
    #1;
    check("R10 valid after reset", int'(outValid), 0);
    check("R10 done after reset", int'(done), 0);
  endtask

  task automatic testBasic();   // R1 R2
    fillMem(1, -1); chanMask = '1; hitLimit = 3'd7;
    checkEvent("R1/R2 basic order", 0, 0);
  endtask

  task automatic testMask();    // R3
    fillMem(2, 5); chanMask = 48'h5A5A_0F0F_F00F; hitLimit = 3'd7;
    checkEvent("R3 mask", 0, 0);
  endtask

  task automatic testLimit();   // R4
    fillMem(3, -1); chanMask = '1; hitLimit = 3'd2;
    checkEvent("R4 limit 2", 0, 0);
    hitLimit = 3'd0;
    checkEvent("R4 limit 0 empty", 0, 0);
  endtask

  task automatic testOdd();     // R5
    fillMem(4, 3); chanMask = 48'h0; chanMask[17] = 1'b1; hitLimit = 3'd7;
    checkEvent("R5 odd total", 0, 0);
    check("R5 lower half zero", int'(gotWords[1][15:0]), 0);
  endtask

  task automatic testCap();     // R8
    fillMem(5, 7); chanMask = '1; hitLimit = 3'd7;
    checkEvent("R8 cap", 0, 0);
    check("R8 96 words", gotN, 96);
    fillMem(6, 4); hitLimit = 3'd4;
    checkEvent("R8 exact fill", 0, 0);
  endtask

  task automatic testBackpressure(); // R6
    fillMem(7, -1); chanMask = 48'hFFFF_FFFF_FFFE; hitLimit = 3'd3;
    checkEvent("R6 backpressure", 1, 0);
  endtask

  task automatic testRetrigger();    // R9
    fillMem(8, -1); chanMask = '1; hitLimit = 3'd5;
    checkEvent("R9 trigger during scan", 1, 1);
  endtask

  initial begin
    fillMem(0, 0);
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testBasic();
    testMask();
    testLimit();
    testOdd();
    testCap();
    testBackpressure();
    testRetrigger();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule